// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor that reports each bus cycle as a three-bit active-low status code. It samples that code on the system clock and steps through the phases of the bus cycle (T1, T2, T3 with optional wait states, T4). In each phase it drives the strobes that the memory and I/O sides need:

- an address latch pulse;
- a data buffer enable and a data direction line;
- separate memory and I/O read and write commands;
- advanced write commands, which open one clock before the normal writes;
- an interrupt acknowledge strobe;
- one shared output whose meaning depends on a bus-mode pin.

In a single-processor system the address-enable input is tied low, command enable is tied high and bus mode is low. In systems with more than one bus master, those inputs allow the block to release its command outputs or to turn the shared output into a peripheral data enable. An interrupt acknowledge takes two status cycles from the processor. The block turns them into two separate acknowledge pulses.

Top module: `bus_cmd_gen`

## Requirements
- R1: After reset, the block is idle. Address latch and data enable are low, data direction is high, every active-low command is high, and the shared enable is low.
- R2: A bus cycle starts only when a clock edge samples a non-passive status (any code other than 111) and the previous edge sampled passive. If a code is held, no second cycle starts. The address latch output is high for exactly the T1 cycle, and this includes halt cycles.
- R3: Status codes are decoded as follows: 000 acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. Code fetch and memory read both drive the memory read strobe. At most one of the five normal commands is active at a time.
- R4: The read strobes (memory, I/O) and the acknowledge strobe are low from T2 through T4, wait states included.
- R5: The normal memory and I/O write strobes are low in T3 and T4. The matching advanced strobe goes low one cycle earlier, in T2, and rises in the same cycle as the normal strobe.
- R6: Data enable is high from T2 through T4 of every cycle that carries a command.
- R7: Data direction is low from T1 through T4 of read, fetch and acknowledge cycles. It stays high for write cycles, for halt cycles and when idle.
- R8: The cycle stays in T3 for as long as the ready input is low at the clock edge.
- R9: A halt cycle drives no command and no data enable.
- R10: While command enable is low, all command strobes are high and both data enable and the peripheral data enable are low.
- R11: While address enable is high, all command strobes are held high. Data enable is not affected.
- R12: With bus mode low, the shared output is high during T1 of acknowledge cycles. With bus mode high, it is high from T2 through T4 of I/O read and I/O write cycles.
- R13: Two consecutive acknowledge status cycles give two separate acknowledge pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_n | input | 3 | Processor bus status, active low |
| ready | input | 1 | Low inserts wait states in T3 |
| addr_en_n | input | 1 | Low lets the command strobes drive |
| cmd_en | input | 1 | High enables commands and data enable |
| bus_mode | input | 1 | Selects the meaning of the shared output |
| addr_latch | output | 1 | Address latch pulse in T1 |
| data_en | output | 1 | Data buffer enable, active high |
| data_dir | output | 1 | High transmit, low receive |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| mem_wr_adv_n | output | 1 | Advanced memory write command |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command |
| io_wr_adv_n | output | 1 | Advanced I/O write command |
| ack_n | output | 1 | Interrupt acknowledge strobe |
| casc_pen | output | 1 | Cascade enable or peripheral data enable |

## Verification
Two pairs of functions share cycles. In T3 and T4 of a write cycle, the advanced and normal write strobes are both low. In T1 of an acknowledge cycle with bus mode low, the address latch pulse and the cascade enable are both high. The sweep provokes both overlaps by running every status code with and without wait states, under every setting of command enable, address enable and bus mode. At each cycle the bench compares all eleven outputs against a phase table it computes from the cycle index and the wait count. A pulse counter confirms that two back-to-back acknowledge cycles give two distinct acknowledge pulses.

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] status_n,
  input  logic       ready,
  input  logic       addr_en_n,
  input  logic       cmd_en,
  input  logic       bus_mode,
  output logic       addr_latch,
  output logic       data_en,
  output logic       data_dir,
  output logic       mem_rd_n,
  output logic       mem_wr_n,
  output logic       mem_wr_adv_n,
  output logic       io_rd_n,
  output logic       io_wr_n,
  output logic       io_wr_adv_n,
  output logic       ack_n,
  output logic       casc_pen
);

  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_T1   = 3'd1;
  localparam logic [2:0] PH_T2   = 3'd2;
  localparam logic [2:0] PH_T3   = 3'd3;
  localparam logic [2:0] PH_T4   = 3'd4;

  localparam logic [2:0] C_ACK  = 3'b000;
  localparam logic [2:0] C_IORD = 3'b001;
  localparam logic [2:0] C_IOWR = 3'b010;
  localparam logic [2:0] C_FTCH = 3'b100;
  localparam logic [2:0] C_MRD  = 3'b101;
  localparam logic [2:0] C_MWR  = 3'b110;
  localparam logic [2:0] C_PASS = 3'b111;

  logic [2:0] ph;
  logic [2:0] code_q;
  logic       prev_pass;

  wire passive = (status_n == C_PASS);
  wire start   = (ph == PH_IDLE) && !passive && prev_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      code_q    <= C_PASS;
      prev_pass <= 1'b1;
    end else begin
      prev_pass <= passive;
      case (ph)
        PH_IDLE: if (start) begin
          ph     <= PH_T1;
          code_q <= status_n;
        end
        PH_T1:   ph <= PH_T2;
        PH_T2:   ph <= PH_T3;
        PH_T3:   if (ready) ph <= PH_T4;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  wire busy = (ph != PH_IDLE);
  wire t1   = (ph == PH_T1);
  wire mid  = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_T4);
  wire late = (ph == PH_T3) || (ph == PH_T4);

  wire is_ack  = (code_q == C_ACK);
  wire is_iord = (code_q == C_IORD);
  wire is_iowr = (code_q == C_IOWR);
  wire is_mrd  = (code_q == C_MRD) || (code_q == C_FTCH);
  wire is_mwr  = (code_q == C_MWR);
  wire rd_cls  = is_ack || is_iord || is_mrd;
  wire cmd_cls = rd_cls || is_iowr || is_mwr;

  wire mrd_r  = mid  && is_mrd;
  wire iord_r = mid  && is_iord;
  wire ack_r  = mid  && is_ack;
  wire mwr_r  = late && is_mwr;
  wire amwr_r = mid  && is_mwr;
  wire iowr_r = late && is_iowr;
  wire aiow_r = mid  && is_iowr;

  wire gate = cmd_en && !addr_en_n;

  assign addr_latch   = t1;
  assign data_en      = mid && cmd_cls && cmd_en;
  assign data_dir     = !(busy && rd_cls);
  assign mem_rd_n     = !(mrd_r  && gate);
  assign mem_wr_n     = !(mwr_r  && gate);
  assign mem_wr_adv_n = !(amwr_r && gate);
  assign io_rd_n      = !(iord_r && gate);
  assign io_wr_n      = !(iowr_r && gate);
  assign io_wr_adv_n  = !(aiow_r && gate);
  assign ack_n        = !(ack_r  && gate);
  assign casc_pen     = bus_mode ? (mid && (is_iord || is_iowr) && cmd_en)
                                 : (t1 && is_ack);

  a_r2_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch |=> !addr_latch);

  a_r3_one_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mrd_r, iord_r, ack_r, mwr_r, iowr_r}));

  a_r5_mem_adv_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mwr_r) |-> $past(amwr_r));

  a_r5_io_adv_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iowr_r) |-> $past(aiow_r));

  a_r5_adv_ends_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amwr_r) |-> $fell(mwr_r));

  a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_T3 && !ready) |=> (ph == PH_T3));

  a_r10_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |-> (&{mem_rd_n, mem_wr_n, mem_wr_adv_n, io_rd_n, io_wr_n,
                   io_wr_adv_n, ack_n} && !data_en));

  a_r7_dir_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n || !mem_rd_n || !io_rd_n) |-> !data_dir);

endmodule

// File: tb/bus_cmd_gen_tb.sv
module bus_cmd_gen_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] status_n = 3'b111;
  logic ready = 1;
  logic addr_en_n = 0;
  logic cmd_en = 1;
  logic bus_mode = 0;
  logic addr_latch, data_en, data_dir, mem_rd_n, mem_wr_n, mem_wr_adv_n;
  logic io_rd_n, io_wr_n, io_wr_adv_n, ack_n, casc_pen;

  int checks = 0;
  int errors = 0;
  int ack_pulses = 0;
  logic ack_prev = 1;

  always #10 clk = ~clk;

  bus_cmd_gen u_dut (
    .clk(clk), .rst_n(rst_n), .status_n(status_n), .ready(ready),
    .addr_en_n(addr_en_n), .cmd_en(cmd_en), .bus_mode(bus_mode),
    .addr_latch(addr_latch), .data_en(data_en), .data_dir(data_dir),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wr_adv_n(mem_wr_adv_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wr_adv_n(io_wr_adv_n),
    .ack_n(ack_n), .casc_pen(casc_pen)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic note_ack();
    if (!ack_n && ack_prev) ack_pulses++;
    ack_prev = ack_n;
  endtask

  task automatic run_one(input logic [2:0] code, input int w,
                         input logic ce, input logic ae, input logic bm);
    logic busy, t1, mid, late, gate;
    logic is_ack, is_ior, is_iow, is_mrd, is_mwr, rd, cmd;
    @(negedge clk);
    status_n = code; cmd_en = ce; addr_en_n = ae; bus_mode = bm; ready = 1;
    is_ack = (code == 3'b000);
    is_ior = (code == 3'b001);
    is_iow = (code == 3'b010);
    is_mrd = (code == 3'b100) || (code == 3'b101);
    is_mwr = (code == 3'b110);
    rd  = is_ack || is_ior || is_mrd;
    cmd = rd || is_iow || is_mwr;
    gate = ce && !ae;
    for (int j = 0; j < 6 + w; j++) begin
      @(negedge clk);
      if (j == 0) status_n = 3'b111;
      ready = !(j >= 2 && j < 2 + w);
      busy = (code != 3'b111) && (j <= 3 + w);
      t1   = busy && (j == 0);
      mid  = busy && (j >= 1);
      late = busy && (j >= 2);
      note_ack();
      chk(addr_latch,   t1,                        "R2 latch");
      chk(data_en,      mid && cmd && ce,          "R6/R9/R10 data_en");
      chk(data_dir,     !(busy && rd),             "R7 dir");
      chk(mem_rd_n,     !(mid && is_mrd && gate),  "R3/R4/R11 mem_rd");
      chk(io_rd_n,      !(mid && is_ior && gate),  "R4/R11 io_rd");
      chk(ack_n,        !(mid && is_ack && gate),  "R4 ack");
      chk(mem_wr_n,     !(late && is_mwr && gate), "R5/R8 mem_wr");
      chk(mem_wr_adv_n, !(mid && is_mwr && gate),  "R5 mem_wr_adv");
      chk(io_wr_n,      !(late && is_iow && gate), "R5/R8 io_wr");
      chk(io_wr_adv_n,  !(mid && is_iow && gate),  "R5 io_wr_adv");
      chk(casc_pen, bm ? (mid && (is_ior || is_iow) && ce) : (t1 && is_ack),
          "R12 casc_pen");
    end
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int lat;
    #35 rst_n = 1;
    @(negedge clk);
    chk(addr_latch, 0, "R1"); chk(data_en, 0, "R1"); chk(data_dir, 1, "R1");
    chk(&{mem_rd_n, mem_wr_n, mem_wr_adv_n, io_rd_n, io_wr_n, io_wr_adv_n, ack_n},
        1, "R1 strobes");
    chk(casc_pen, 0, "R1");

    for (int c = 0; c < 8; c++)
      for (int wi = 0; wi < 2; wi++)
        for (int cfg = 0; cfg < 8; cfg++)
          run_one(3'(c), wi * 2, cfg[0], cfg[1], cfg[2]);

    ack_pulses = 0; ack_prev = 1;
    run_one(3'b000, 0, 1, 0, 0);
    run_one(3'b000, 1, 1, 0, 0);
    chk(ack_pulses == 2, 1, "R13 two pulses");

    lat = 0;
    @(negedge clk);
    status_n = 3'b101;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (addr_latch) lat++;
    end
    chk(lat == 1, 1, "R2 held code one cycle");
    status_n = 3'b111;
    repeat (3) @(negedge clk);
    chk(addr_latch, 0, "R2 passive");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule